// File: doc/BRIEF.md
# Luma/Chroma Word Interleaver with Sync-Code Normalization

This block takes a 20-bit video pair word, one 10-bit luma sample and one 10-bit chroma sample, and turns it into a single 10-bit word stream at twice the pair rate. It runs on one clock at the doubled rate. An internal phase toggle lets the block capture a pair on every other clock edge. On the two edges that follow a capture, the block emits the chroma word and then the luma word.

Every emitted word passes through a sync-code normalizer before the output register. The normalizer looks at the eight most significant bits of the word. When they are all zeros, it drives the two least significant bits to zeros. When they are all ones, it drives them to ones. This way a source that carries only 8 significant bits still produces the exact 10-bit timing reference codes. A bypass input turns the normalizer off, for streams that do not follow the video timing-code convention.

Upstream logic watches the `pair_take` output and presents a new pair on each cycle where it is high. A valid flag travels with each pair and marks both of the words that come from it.

Top module: `yci_interleaver`

## Requirements
- R1: `pair_take` is high during reset and in the first cycle after reset, and then inverts on every clock edge.
- R2: The pair is captured only at an edge where `pair_take` is high. The luma sample sits in `pair_in[19:10]` and the chroma sample in `pair_in[9:0]`. Values on `pair_in` and `pair_valid` at other edges have no effect on the output.
- R3: The chroma word of a captured pair appears on `out_word` after the first edge following capture. The luma word appears after the second edge.
- R4: `out_valid` is high for both words of a pair whose `pair_valid` was high at capture, and low for both words of a pair captured with `pair_valid` low.
- R5: With `norm_off` low at the output edge, a word whose bits [9:2] are all zeros leaves with bits [1:0] = 00.
- R6: With `norm_off` low at the output edge, a word whose bits [9:2] are all ones leaves with bits [1:0] = 11.
- R7: A word whose bits [9:2] are neither all zeros nor all ones leaves unchanged.
- R8: With `norm_off` high at the edge that loads a word into the output register, that word leaves unchanged. `norm_off` is sampled separately for each word.
- R9: While `rst` is high, `out_word` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the pair rate |
| rst | input | 1 | Synchronous active-high reset |
| pair_in | input | 20 | Luma in [19:10], chroma in [9:0] |
| pair_valid | input | 1 | Marks `pair_in` as carrying a real pair |
| norm_off | input | 1 | High bypasses sync-code normalization |
| pair_take | output | 1 | High when the next edge captures `pair_in` |
| out_word | output | 10 | Interleaved, normalized word |
| out_valid | output | 1 | Marks `out_word` as belonging to a valid pair |

## Verification
A phase toggle that slips shows up within one edge. `pair_take` stops alternating, and the words come out swapped or repeated, with luma where chroma is expected. A corrupted holding register shows on `out_word` one edge after capture. A wrong normalizer decision shows in the low two bits of the same word that triggered it. The bench drives codes just inside and just outside the reserved bands, and toggles the bypass between the two words of a pair, so a decision that uses the wrong bits or the wrong cycle's bypass is caught on the very next sample.

// File: rtl/yci_pkg.sv
package yci_pkg;
   localparam int unsigned YCI_WORD_W  = 10;
   localparam int unsigned YCI_FORCE_W = 2;

   // Phase of the doubled-rate clock relative to the pair rate
   typedef enum logic {
      PH_LOAD = 1'b0,   // next edge captures a new pair
      PH_HOLD = 1'b1    // next edge emits the first word of the held pair
   } yci_phase_e;
endpackage

// File: rtl/yci_pair_capture.sv
module yci_pair_capture
   import yci_pkg::*;
#(
   parameter int unsigned WORD_W = YCI_WORD_W,
   localparam int unsigned PAIR_W = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PAIR_W-1:0] pair_in,
   input  logic              pair_valid,
   output logic              take,
   output logic              first_slot,
   output logic [WORD_W-1:0] hold_y,
   output logic [WORD_W-1:0] hold_c,
   output logic              hold_vld
);
   yci_phase_e phase_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_LOAD;
      end else begin
         phase_q <= (phase_q == PH_LOAD) ? PH_HOLD : PH_LOAD;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_y   <= '0;
         hold_c   <= '0;
         hold_vld <= 1'b0;
      end else if (phase_q == PH_LOAD) begin
         hold_y   <= pair_in[PAIR_W-1:WORD_W];
         hold_c   <= pair_in[WORD_W-1:0];
         hold_vld <= pair_valid;
      end
   end

   assign take       = (phase_q == PH_LOAD);
   assign first_slot = (phase_q == PH_HOLD);
endmodule

// File: rtl/yci_word_select.sv
module yci_word_select #(
   parameter int unsigned WORD_W       = 10,
   parameter bit          CHROMA_FIRST = 1'b1
) (
   input  logic              first_slot,
   input  logic [WORD_W-1:0] hold_y,
   input  logic [WORD_W-1:0] hold_c,
   output logic [WORD_W-1:0] sel_word
);
   generate
      if (CHROMA_FIRST) begin : g_c_first
         always_comb sel_word = first_slot ? hold_c : hold_y;
      end else begin : g_y_first
         always_comb sel_word = first_slot ? hold_y : hold_c;
      end
   endgenerate
endmodule

// File: rtl/yci_sync_norm.sv
module yci_sync_norm #(
   parameter int unsigned WORD_W  = 10,
   parameter int unsigned FORCE_W = 2,
   localparam int unsigned HIGH_W = WORD_W - FORCE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] sel_word,
   input  logic              sel_vld,
   input  logic              norm_off,
   output logic [WORD_W-1:0] out_word,
   output logic              out_valid
);
   logic [HIGH_W-1:0]  high_part;
   logic               high_zero;
   logic               high_ones;
   logic [FORCE_W-1:0] low_next;

   assign high_part = sel_word[WORD_W-1:FORCE_W];
   assign high_zero = (high_part == '0);
   assign high_ones = (&high_part);

   always_comb begin
      low_next = sel_word[FORCE_W-1:0];
      if (!norm_off) begin
         if (high_zero) low_next = '0;
         else if (high_ones) low_next = '1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_word  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_word  <= {high_part, low_next};
         out_valid <= sel_vld;
      end
   end
endmodule

// File: rtl/yci_interleaver.sv
module yci_interleaver
   import yci_pkg::*;
#(
   parameter int unsigned WORD_W       = YCI_WORD_W,
   parameter int unsigned FORCE_W      = YCI_FORCE_W,
   parameter bit          CHROMA_FIRST = 1'b1,
   localparam int unsigned PAIR_W      = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PAIR_W-1:0] pair_in,
   input  logic              pair_valid,
   input  logic              norm_off,
   output logic              pair_take,
   output logic [WORD_W-1:0] out_word,
   output logic              out_valid
);
   generate
      if (FORCE_W < 1 || FORCE_W >= WORD_W) begin : g_bad_force
         $error("yci_interleaver: FORCE_W must lie in 1..WORD_W-1");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("yci_interleaver: WORD_W must be at least 2");
      end
   endgenerate

   logic              first_slot;
   logic [WORD_W-1:0] hold_y;
   logic [WORD_W-1:0] hold_c;
   logic              hold_vld;
   logic [WORD_W-1:0] sel_word;

   yci_pair_capture #(.WORD_W(WORD_W)) u_capture (
      .clk        (clk),
      .rst        (rst),
      .pair_in    (pair_in),
      .pair_valid (pair_valid),
      .take       (pair_take),
      .first_slot (first_slot),
      .hold_y     (hold_y),
      .hold_c     (hold_c),
      .hold_vld   (hold_vld)
   );

   yci_word_select #(.WORD_W(WORD_W), .CHROMA_FIRST(CHROMA_FIRST)) u_select (
      .first_slot (first_slot),
      .hold_y     (hold_y),
      .hold_c     (hold_c),
      .sel_word   (sel_word)
   );

   yci_sync_norm #(.WORD_W(WORD_W), .FORCE_W(FORCE_W)) u_norm (
      .clk       (clk),
      .rst       (rst),
      .sel_word  (sel_word),
      .sel_vld   (hold_vld),
      .norm_off  (norm_off),
      .out_word  (out_word),
      .out_valid (out_valid)
   );
endmodule

// File: rtl/yci_checker.sv
module yci_checker #(
   parameter int unsigned WORD_W  = 10,
   parameter int unsigned FORCE_W = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              pair_take,
   input logic              pair_valid,
   input logic              norm_off,
   input logic [WORD_W-1:0] sel_word,
   input logic [WORD_W-1:0] out_word,
   input logic              out_valid
);
   assert_take_low_R1: assert property (@(posedge clk) disable iff (rst)
      pair_take |=> !pair_take);

   assert_take_high_R1: assert property (@(posedge clk) disable iff (rst)
      !pair_take |=> pair_take);

   assert_valid_pair_R4: assert property (@(posedge clk) disable iff (rst)
      (pair_take && pair_valid) |=> ##1 (out_valid ##1 out_valid));

   assert_invalid_pair_R4: assert property (@(posedge clk) disable iff (rst)
      (pair_take && !pair_valid) |=> ##1 (!out_valid ##1 !out_valid));

   assert_force_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (!norm_off && (sel_word[WORD_W-1:FORCE_W] == '0))
      |=> (out_word[FORCE_W-1:0] == '0));

   assert_force_ones_R6: assert property (@(posedge clk) disable iff (rst)
      (!norm_off && (&sel_word[WORD_W-1:FORCE_W]))
      |=> (&out_word[FORCE_W-1:0]));

   assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
      norm_off |=> (out_word == $past(sel_word)));

   assert_quiet_reset_R9: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && (out_word == '0)));
endmodule

bind yci_interleaver yci_checker #(.WORD_W(WORD_W), .FORCE_W(FORCE_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .pair_take  (pair_take),
   .pair_valid (pair_valid),
   .norm_off   (norm_off),
   .sel_word   (sel_word),
   .out_word   (out_word),
   .out_valid  (out_valid)
);

// File: tb/yci_interleaver_tb.sv
module yci_interleaver_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [19:0] pair_in = '0;
   logic        pair_valid = 1'b0;
   logic        norm_off = 1'b0;
   logic        pair_take;
   logic [9:0]  out_word;
   logic        out_valid;

   int n_vec  = 0;
   int n_bad  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   yci_interleaver u_dut (
      .clk        (clk),
      .rst        (rst),
      .pair_in    (pair_in),
      .pair_valid (pair_valid),
      .norm_off   (norm_off),
      .pair_take  (pair_take),
      .out_word   (out_word),
      .out_valid  (out_valid)
   );

   function automatic logic [9:0] expect_word(input logic [9:0] w, input logic off);
      if (off) return w;
      if (w[9:2] == 8'h00) return {w[9:2], 2'b00};
      if (w[9:2] == 8'hFF) return {w[9:2], 2'b11};
      return w;
   endfunction

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One pair through the block: capture, then chroma word, then luma word.
   task automatic send_pair(input string tag, input logic [9:0] y, input logic [9:0] c,
                            input logic v, input logic off_c, input logic off_y);
      @(negedge clk);
      while (!pair_take) @(negedge clk);
      pair_in    = {y, c};
      pair_valid = v;
      @(negedge clk);
      // R2: junk on the non-capture edge must not reach the output
      pair_in    = ~{y, c};
      pair_valid = ~v;
      norm_off   = off_c;
      @(negedge clk);
      pair_valid = 1'b0;
      check({tag, " R3 chroma word"}, out_word, expect_word(c, off_c));
      check({tag, " R4 chroma valid"}, {9'b0, out_valid}, {9'b0, v});
      norm_off = off_y;
      @(negedge clk);
      check({tag, " R2 R3 luma word"}, out_word, expect_word(y, off_y));
      check({tag, " R4 luma valid"}, {9'b0, out_valid}, {9'b0, v});
      norm_off = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      pair_in    = 20'hFFFFF;
      pair_valid = 1'b1;
      @(negedge clk);
      check("R9 word in reset", out_word, 10'h000);
      check("R9 valid in reset", {9'b0, out_valid}, 10'h000);
      check("R1 take in reset", {9'b0, pair_take}, 10'h001);
      pair_valid = 1'b0;
      pair_in    = '0;
      rst        = 1'b0;
      check("R1 take after reset", {9'b0, pair_take}, 10'h001);
      @(negedge clk);
      check("R1 take toggles low", {9'b0, pair_take}, 10'h000);
      @(negedge clk);
      check("R1 take toggles high", {9'b0, pair_take}, 10'h001);
   endtask

   task automatic t_plain();
      send_pair("R7 plain", 10'h2A5, 10'h1C3, 1'b1, 1'b0, 1'b0);
      send_pair("R7 near band", 10'h3FB, 10'h004, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_zero_band();
      send_pair("R5 zero band", 10'h001, 10'h003, 1'b1, 1'b0, 1'b0);
      send_pair("R5 zero exact", 10'h000, 10'h002, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_ones_band();
      send_pair("R6 ones band", 10'h3FD, 10'h3FC, 1'b1, 1'b0, 1'b0);
      send_pair("R6 ones exact", 10'h3FF, 10'h3FE, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_bypass();
      send_pair("R8 bypass both", 10'h3FE, 10'h001, 1'b1, 1'b1, 1'b1);
      send_pair("R8 bypass chroma only", 10'h002, 10'h002, 1'b1, 1'b1, 1'b0);
      send_pair("R8 bypass luma only", 10'h3FC, 10'h3FC, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_invalid();
      send_pair("R4 invalid pair", 10'h155, 10'h0AA, 1'b0, 1'b0, 1'b0);
      send_pair("R4 valid again", 10'h0F0, 10'h30F, 1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_plain();
      t_zero_band();
      t_ones_band();
      t_bypass();
      t_invalid();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog R3 actual=hung expected=complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule